// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 128-bit packed integer execution unit. Each source operand is viewed as a set of independent lanes whose width (8, 16 or 32 bits) is picked by a run-time select. The same operation is then applied to every lane at once. The available operations are wrap-around add and subtract, signed minimum and maximum, bitwise AND/OR/XOR, three kinds of per-lane shift, and a per-lane count of leading zeros. A separate funnel-shift operation treats the two sources as one 256-bit value and extracts a 128-bit window at a byte offset.

The lane datapath is built as two 64-bit halves that run side by side. Each half holds lane slices for every supported width, and the lane-width select chooses which set drives the result. The funnel shifter sits beside the halves. The selected value is registered, so a result appears one clock after an operation is issued with `valid_in`. The result register keeps its value while no operation is issued.

Top module: `simd_alu`

## Requirements
- R1: Opcode 0 (add) adds the two sources lane by lane, modulo the lane width, with no carry crossing a lane boundary; lane_w 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes.
- R2: Opcode 1 (subtract) computes src_a minus src_b in each lane, modulo the lane width, with no borrow crossing a lane boundary.
- R3: Opcode 2 (min) and opcode 3 (max) return, in each lane, the smaller or larger of the two lanes compared as signed two's-complement values.
- R4: Opcodes 4, 5 and 6 return the bitwise AND, OR and XOR of the sources, and the result does not depend on lane_w.
- R5: Opcodes 7, 8 and 9 shift each src_a lane left logically, right logically and right arithmetically, by shamt modulo the lane width (the low 3, 4 or 5 bits of shamt).
- R6: Opcode 10 returns in each lane the number of leading zero bits of the src_a lane, and an all-zero lane returns the lane width.
- R7: Opcode 11 (funnel) returns bits [8k+127 : 8k] of the 256-bit value {src_b, src_a}, where k is shamt[3:0]; k = 0 returns src_a unchanged.
- R8: A result is presented one clock after the cycle in which valid_in is high, and valid_out is high exactly in the cycle after valid_in was high.
- R9: While valid_in is low the result output keeps its previous value.
- R10: While rst is high at a clock edge, valid_out and result are cleared to zero.
- R11: Opcodes 12 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Issues an operation this cycle |
| op | input | 4 | Operation code |
| lane_w | input | 2 | Lane width select: 0 = 8, 1 = 16, 2/3 = 32 bits |
| src_a | input | 128 | First source; lower half of the funnel value |
| src_b | input | 128 | Second source; upper half of the funnel value |
| shamt | input | 5 | Lane shift amount, or byte offset of the funnel in bits 3:0 |
| valid_out | output | 1 | Result is new this cycle |
| result | output | 128 | Registered result |

## Verification
Directed operands place all-ones and one next to each other in every lane, so a carry or borrow that leaks into the next lane changes the result. Other directed cases put 0x80 against 0x7F, which separates a signed compare from an unsigned one. Shift amounts are chosen larger than the lane width to show that only the low bits count. Zero and one-bit lanes probe the ends of the leading-zero count, and funnel offsets 0 and 15 probe the ends of the window. Random operands over all opcodes, widths and amounts then compare every result bit against a lane-by-lane model, and idle cycles with changing inputs show whether the result register holds its value.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MIN = 4'd2,
    OP_MAX = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_SLL = 4'd7,
    OP_SRL = 4'd8,
    OP_SRA = 4'd9,
    OP_LZC = 4'd10,
    OP_FSH = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2
  } lane_w_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int LW = 8
) (
  input  op_e                     op,
  input  logic [LW-1:0]           a,
  input  logic [LW-1:0]           b,
  input  logic [$clog2(LW)-1:0]   amt,
  output logic [LW-1:0]           y
);
  localparam int AW = $clog2(LW);
  localparam int CW = AW + 1;

  logic [CW-1:0] zeros;

  always_comb begin
    zeros = CW'(LW);
    for (int i = 0; i < LW; i++) begin
      if (a[i]) zeros = CW'(LW - 1 - i);
    end
  end

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MIN:  y = ($signed(a) < $signed(b)) ? a : b;
      OP_MAX:  y = ($signed(a) > $signed(b)) ? a : b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SLL:  y = a << amt;
      OP_SRL:  y = a >> amt;
      OP_SRA:  y = LW'($signed(a) >>> amt);
      OP_LZC:  y = LW'(zeros);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_half.sv
module simd_half
  import simd_pkg::*;
#(
  parameter int HW  = 64,
  parameter int SHW = 5
) (
  input  op_e             op,
  input  logic [1:0]      lane_w,
  input  logic [HW-1:0]   a,
  input  logic [HW-1:0]   b,
  input  logic [SHW-1:0]  sh,
  output logic [HW-1:0]   y
);
  localparam int N8  = HW / 8;
  localparam int N16 = HW / 16;
  localparam int N32 = HW / 32;

  logic [HW-1:0] y8, y16, y32;

  for (genvar g = 0; g < N8; g++) begin : g_l8
    simd_lane #(.LW(8)) u_lane (
      .op(op), .a(a[g*8 +: 8]), .b(b[g*8 +: 8]),
      .amt(sh[2:0]), .y(y8[g*8 +: 8])
    );
  end

  for (genvar g = 0; g < N16; g++) begin : g_l16
    simd_lane #(.LW(16)) u_lane (
      .op(op), .a(a[g*16 +: 16]), .b(b[g*16 +: 16]),
      .amt(sh[3:0]), .y(y16[g*16 +: 16])
    );
  end

  for (genvar g = 0; g < N32; g++) begin : g_l32
    simd_lane #(.LW(32)) u_lane (
      .op(op), .a(a[g*32 +: 32]), .b(b[g*32 +: 32]),
      .amt(sh[4:0]), .y(y32[g*32 +: 32])
    );
  end

  always_comb begin
    case (lane_w)
      LW_8:    y = y8;
      LW_16:   y = y16;
      default: y = y32;
    endcase
  end
endmodule

// File: rtl/simd_funnel.sv
module simd_funnel #(
  parameter int DW = 128
) (
  input  logic [DW-1:0]             lo,
  input  logic [DW-1:0]             hi,
  input  logic [$clog2(DW/8)-1:0]   byte_amt,
  output logic [DW-1:0]             y
);
  localparam int BW = $clog2(DW / 8);

  logic [BW+2:0] bit_amt;

  always_comb begin
    bit_amt = {byte_amt, 3'b000};
    y       = DW'({hi, lo} >> bit_amt);
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DW  = 128,
  parameter int SHW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_in,
  input  logic [3:0]      op,
  input  logic [1:0]      lane_w,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  input  logic [SHW-1:0]  shamt,
  output logic            valid_out,
  output logic [DW-1:0]   result
);
  localparam int HW  = 64;
  localparam int NH  = DW / HW;
  localparam int FBW = $clog2(DW / 8);

  op_e           op_q;
  logic [DW-1:0] lane_y;
  logic [DW-1:0] fun_y;
  logic [DW-1:0] next_y;

  assign op_q = op_e'(op);

  for (genvar h = 0; h < NH; h++) begin : g_half
    simd_half #(.HW(HW), .SHW(SHW)) u_half (
      .op(op_q), .lane_w(lane_w),
      .a(src_a[h*HW +: HW]), .b(src_b[h*HW +: HW]),
      .sh(shamt), .y(lane_y[h*HW +: HW])
    );
  end

  simd_funnel #(.DW(DW)) u_funnel (
    .lo(src_a), .hi(src_b), .byte_amt(shamt[FBW-1:0]), .y(fun_y)
  );

  always_comb begin
    if (op_q == OP_FSH)      next_y = fun_y;
    else if (op <= 4'd10)    next_y = lane_y;
    else                     next_y = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      result    <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) result <= next_y;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DW  = 128,
  parameter int SHW = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_in,
  input logic [3:0]      op,
  input logic [1:0]      lane_w,
  input logic [DW-1:0]   src_a,
  input logic [DW-1:0]   src_b,
  input logic [SHW-1:0]  shamt,
  input logic            valid_out,
  input logic [DW-1:0]   result
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(result)); // R9
  AST_ADD32_LANE0: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op == 4'd0 && lane_w == 2'd2)
      |=> result[31:0] == $past(src_a[31:0] + src_b[31:0])); // R1
  AST_AND_ALL: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op == 4'd4) |=> result == $past(src_a & src_b)); // R4
  AST_FUNNEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op == 4'd11 && shamt[3:0] == 4'd0) |=> result == $past(src_a)); // R7
  AST_SPARE_OP: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op >= 4'd12) |=> result == '0); // R11
endmodule

bind simd_alu simd_alu_chk #(.DW(DW), .SHW(SHW)) u_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in), .op(op), .lane_w(lane_w),
  .src_a(src_a), .src_b(src_b), .shamt(shamt),
  .valid_out(valid_out), .result(result)
);

// File: tb/test_simd_alu.sv
module test_simd_alu;
  logic         clk = 1'b0;
  logic         rst;
  logic         valid_in;
  logic [3:0]   op;
  logic [1:0]   lane_w;
  logic [127:0] src_a, src_b;
  logic [4:0]   shamt;
  logic         valid_out;
  logic [127:0] result;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  simd_alu i_simd_alu (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op(op), .lane_w(lane_w),
    .src_a(src_a), .src_b(src_b), .shamt(shamt),
    .valid_out(valid_out), .result(result)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5, 4'd6: return "R4";
      4'd7, 4'd8, 4'd9: return "R5";
      4'd10: return "R6";
      4'd11: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [127:0] model(input logic [3:0] o, input logic [1:0] w,
      input logic [127:0] a, input logic [127:0] b, input logic [4:0] sh);
    int lw;
    logic [127:0] r;
    logic [31:0] mask;
    lw = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    mask = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 32'd1);
    r = '0;
    if (o == 4'd11) return 128'({b, a} >> (8 * int'(sh[3:0])));
    if (o > 4'd11) return '0;
    for (int i = 0; i < 128 / lw; i++) begin
      logic [31:0] x, y, z;
      longint sx, sy;
      int amt;
      x = 32'(a >> (i * lw)) & mask;
      y = 32'(b >> (i * lw)) & mask;
      sx = x[lw-1] ? longint'(x) - (longint'(1) << lw) : longint'(x);
      sy = y[lw-1] ? longint'(y) - (longint'(1) << lw) : longint'(y);
      amt = int'(sh) % lw;
      case (o)
        4'd0: z = x + y;
        4'd1: z = x - y;
        4'd2: z = (sx < sy) ? x : y;
        4'd3: z = (sx > sy) ? x : y;
        4'd4: z = x & y;
        4'd5: z = x | y;
        4'd6: z = x ^ y;
        4'd7: z = x << amt;
        4'd8: z = x >> amt;
        4'd9: z = 32'(sx >>> amt);
        default: begin
          z = 32'(lw);
          for (int k = lw - 1; k >= 0; k--) begin
            if (x[k]) begin z = 32'(lw - 1 - k); break; end
          end
        end
      endcase
      z = z & mask;
      r = r | (128'(z) << (i * lw));
    end
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [1:0] w,
      input logic [127:0] a, input logic [127:0] b, input logic [4:0] sh);
    logic [127:0] exp;
    logic [127:0] held;
    exp = model(o, w, a, b, sh);
    @(negedge clk);
    valid_in = 1'b1; op = o; lane_w = w; src_a = a; src_b = b; shamt = sh;
    @(negedge clk);
    check(req_of(o), "result", result, exp);
    check("R8", "valid_out high", 128'(valid_out), 128'd1);
    held = result;
    valid_in = 1'b0; op = 4'($urandom); src_a = {4{$urandom}}; src_b = {4{$urandom}};
    @(negedge clk);
    check("R8", "valid_out low", 128'(valid_out), 128'd0);
    check("R9", "hold while idle", result, held);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; valid_in = 1'b0; op = '0; lane_w = '0;
    src_a = '0; src_b = '0; shamt = '0;
    @(negedge clk);
    valid_in = 1'b1; op = 4'd5; src_a = '1; src_b = '1;
    repeat (2) @(negedge clk);
    check("R10", "reset result", result, '0);
    check("R10", "reset valid", 128'(valid_out), '0);
    valid_in = 1'b0;
    rst = 1'b0;

    // R1 carry isolation in each width
    run_op(4'd0, 2'd0, {16{8'hFF}}, {16{8'h01}}, 5'd0);
    run_op(4'd0, 2'd1, {8{16'hFFFF}}, {8{16'h0001}}, 5'd0);
    run_op(4'd0, 2'd3, {4{32'hFFFF_FFFF}}, {4{32'h1}}, 5'd0);
    // R2 borrow isolation
    run_op(4'd1, 2'd1, '0, {8{16'h0001}}, 5'd0);
    // R3 signed compare
    run_op(4'd2, 2'd0, {16{8'h80}}, {16{8'h7F}}, 5'd0);
    run_op(4'd3, 2'd0, {16{8'h80}}, {16{8'h7F}}, 5'd0);
    // R4 logic, width-independent
    run_op(4'd6, 2'd0, {4{32'hA5A5_0F0F}}, {4{32'h5A5A_FF00}}, 5'd0);
    // R5 shift amount modulo lane width
    run_op(4'd7, 2'd0, {16{8'h81}}, '0, 5'd9);
    run_op(4'd9, 2'd1, {8{16'h8000}}, '0, 5'd19);
    run_op(4'd8, 2'd2, {4{32'h8000_0000}}, '0, 5'd31);
    // R6 leading zeros: zero lanes and top-bit lanes
    run_op(4'd10, 2'd0, {8{16'h0080}}, '0, 5'd0);
    run_op(4'd10, 2'd2, {32'h0, 32'h1, 32'h8000_0000, 32'h0001_0000}, '0, 5'd0);
    // R7 funnel ends
    run_op(4'd11, 2'd0, {4{32'h1234_5678}}, {4{32'h9ABC_DEF0}}, 5'd16);
    run_op(4'd11, 2'd0, {4{32'h1234_5678}}, {4{32'h9ABC_DEF0}}, 5'd15);
    // R11 spare opcode
    run_op(4'd13, 2'd0, '1, '1, 5'd3);

    for (int n = 0; n < 400; n++) begin
      run_op(4'($urandom_range(0, 15)), 2'($urandom), {4{$urandom}}, {4{$urandom}},
             5'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule